// File: doc/BRIEF.md
# Multi-Agent Hardware Mutex Register

This block is a single hardware lock that up to sixteen software agents share through a small 32-bit register bus. Each agent owns one bit position in two registers: a pending-request register and an ownership register. An agent asks for the lock by writing a one to its bit in the request register. While the lock is free, the block hands it to the lowest-numbered waiting agent.

An agent gives up the lock by writing a one to its own bit in the ownership register. The same write from an agent that does not hold the lock withdraws its waiting request instead. Zeros written to either register change nothing. A one-cycle pulse output marks every change of owner, so a neighbouring block can react without polling.

The request register sits at word address 0 and the ownership register at word address 1. Bit i of each register belongs to agent i. Reads return the register in the low bits and zeros above them. Every other address reads as zero and ignores writes.

Top module: `mutex_lock_reg`

## Requirements
- R1: A write to address 0 sets request bit i for every bit i of the write data that is 1 (bits at or above the agent count are ignored), and the bit reads back as 1 from address 0.
- R2: A request bit stays at 1 until that agent is granted the lock or cancels the request.
- R3: Zero bits written to address 0 leave the request register unchanged.
- R4: The ownership register (address 1) has at most one bit set at any time.
- R5: When no agent holds the lock and nothing is pending, address 1 reads 0.
- R6: Writing 1 to the ownership bit that is currently set clears it, which frees the lock. A request bit the owner also holds stays pending.
- R7: Writing 1 to an ownership bit that is clear removes that agent's pending request.
- R8: When the lock is free and requests are pending, on the next clock the lowest-numbered pending agent gets its ownership bit set and its request bit cleared. A request cancelled in that same cycle is not eligible.
- R9: In the cycle a release takes effect the lock stays free. The next owner is granted one clock later.
- R10: `owner_changed` is high for exactly the one cycle that follows each clock edge at which the ownership register changed value.
- R11: Asserting `rst_n` low clears both registers and `owner_changed`.
- R12: Addresses other than 0 and 1 read as zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Word address of the access |
| wr_en | input | 1 | Write strobe for the current cycle |
| wr_data | input | 32 | Write data, one bit per agent |
| rd_data | output | 32 | Combinational read data for `addr` |
| owner_changed | output | 1 | One-cycle pulse after any change of owner |

## Verification
The bound checker looks at every cycle for these properties: at most one owner exists, request bits hold while the lock is held, and zero writes change nothing. It also checks that a release frees the lock for one full cycle, that a cancel removes the request, that a free lock goes to the lowest pending agent, and that the change pulse agrees with the owner history. Some behaviour needs whole scenarios and only the bench's sequences show it. These scenarios are an owner that asks again and is re-granted after releasing, a cancel that arrives in the same cycle the arbiter would have picked that agent, out-of-range data bits, writes to unmapped addresses, and a reset that arrives while the lock is held.

// File: rtl/mutex_lock_reg.sv
module mutex_lock_reg #(
  parameter int N        = 16,
  parameter int DW       = 32,
  parameter int AW       = 4,
  parameter int REQ_ADDR = 0,
  parameter int OWN_ADDR = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          owner_changed
);
  localparam logic [AW-1:0] REQ_A = AW'(REQ_ADDR);
  localparam logic [AW-1:0] OWN_A = AW'(OWN_ADDR);
  localparam logic [N-1:0]  ONE   = N'(1);

  logic [N-1:0] req_q, own_q, req_d, own_d;
  logic [N-1:0] set_req, own_wr, withdraw, waiting, pick;
  logic         unused_hi;

  assign unused_hi = ^wr_data;

  assign set_req  = (wr_en && addr == REQ_A) ? wr_data[N-1:0] : '0;
  assign own_wr   = (wr_en && addr == OWN_A) ? wr_data[N-1:0] : '0;
  assign withdraw = own_wr & ~own_q;
  assign waiting  = req_q & ~withdraw;
  assign pick     = (own_q == '0) ? (waiting & (~waiting + ONE)) : '0;

  assign own_d = (own_q & ~own_wr) | pick;
  assign req_d = (waiting | set_req) & ~pick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q         <= '0;
      own_q         <= '0;
      owner_changed <= 1'b0;
    end else begin
      req_q         <= req_d;
      own_q         <= own_d;
      owner_changed <= (own_d != own_q);
    end
  end

  always_comb begin
    rd_data = '0;
    if (addr == REQ_A)      rd_data[N-1:0] = req_q;
    else if (addr == OWN_A) rd_data[N-1:0] = own_q;
  end
endmodule

// File: rtl/mutex_lock_reg_chk.sv
module mutex_lock_reg_chk #(
  parameter int N        = 16,
  parameter int DW       = 32,
  parameter int AW       = 4,
  parameter int REQ_ADDR = 0,
  parameter int OWN_ADDR = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          wr_en,
  input logic [DW-1:0] wr_data,
  input logic [N-1:0]  req_q,
  input logic [N-1:0]  own_q,
  input logic          owner_changed
);
  localparam logic [N-1:0] ONE = N'(1);

  logic         req_wr, own_wr;
  logic [N-1:0] wbits, lowest;

  assign req_wr = wr_en && addr == AW'(REQ_ADDR);
  assign own_wr = wr_en && addr == AW'(OWN_ADDR);
  assign wbits  = wr_data[N-1:0];
  assign lowest = req_q & (~req_q + ONE);

  p_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && own_q != '0) |=> ((req_q & $past(wbits)) == $past(wbits)));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q != '0 && !own_wr) |=> ((req_q & $past(req_q)) == $past(req_q)));

  p_zero_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && wbits == '0 && own_q != '0) |=> $stable(req_q));

  p_one_owner_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(own_q));

  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (own_wr && (wbits & own_q) != '0) |=> own_q == '0);

  p_cancel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (own_wr && (wbits & own_q) == '0) |=> (req_q & $past(wbits)) == '0);

  p_grant_lowest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q == '0 && req_q != '0 && !own_wr) |=> own_q == $past(lowest));

  p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> owner_changed == (own_q != $past(own_q)));
endmodule

bind mutex_lock_reg mutex_lock_reg_chk #(
  .N(N), .DW(DW), .AW(AW), .REQ_ADDR(REQ_ADDR), .OWN_ADDR(OWN_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .req_q(req_q), .own_q(own_q), .owner_changed(owner_changed)
);

// File: tb/mutex_lock_reg_test.sv
`timescale 1ns/100ps
module mutex_lock_reg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        owner_changed;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  mutex_lock_reg uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .owner_changed(owner_changed)
  );

  typedef struct packed {
    logic        we;
    logic [3:0]  a;
    logic [31:0] d;
    logic [15:0] exp_req;
    logic [15:0] exp_own;
    logic        exp_chg;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 4'd0, 32'h0000_0024, 16'h0024, 16'h0000, 1'b0},
    '{1'b0, 4'd0, 32'h0000_0000, 16'h0020, 16'h0004, 1'b1},
    '{1'b1, 4'd0, 32'h0000_0001, 16'h0021, 16'h0004, 1'b0},
    '{1'b1, 4'd0, 32'h0000_0000, 16'h0021, 16'h0004, 1'b0},
    '{1'b1, 4'd1, 32'h0000_0001, 16'h0020, 16'h0004, 1'b0},
    '{1'b1, 4'd1, 32'h0000_0004, 16'h0020, 16'h0000, 1'b1},
    '{1'b0, 4'd0, 32'h0000_0000, 16'h0000, 16'h0020, 1'b1},
    '{1'b1, 4'd0, 32'h0000_8000, 16'h8000, 16'h0020, 1'b0},
    '{1'b1, 4'd1, 32'h0000_8020, 16'h0000, 16'h0000, 1'b1},
    '{1'b0, 4'd0, 32'h0000_0000, 16'h0000, 16'h0000, 1'b0},
    '{1'b1, 4'd2, 32'h0000_FFFF, 16'h0000, 16'h0000, 1'b0},
    '{1'b1, 4'd0, 32'hFFFF_0100, 16'h0100, 16'h0000, 1'b0},
    '{1'b0, 4'd0, 32'h0000_0000, 16'h0000, 16'h0100, 1'b1},
    '{1'b1, 4'd0, 32'h0000_0100, 16'h0100, 16'h0100, 1'b0},
    '{1'b1, 4'd1, 32'h0000_0100, 16'h0100, 16'h0000, 1'b1},
    '{1'b0, 4'd0, 32'h0000_0000, 16'h0000, 16'h0100, 1'b1},
    '{1'b1, 4'd1, 32'h0000_0100, 16'h0000, 16'h0000, 1'b1},
    '{1'b1, 4'd0, 32'h0000_0006, 16'h0006, 16'h0000, 1'b0},
    '{1'b1, 4'd1, 32'h0000_0002, 16'h0000, 16'h0004, 1'b1},
    '{1'b1, 4'd1, 32'h0000_0004, 16'h0000, 16'h0000, 1'b1}
  };

  function automatic string tag_of(int i);
    case (i)
      0, 7, 11: return "R1";
      2, 13:    return "R2";
      3:        return "R3";
      4:        return "R7";
      5:        return "R6/R9";
      6:        return "R9";
      8:        return "R6/R7";
      9:        return "R5";
      10:       return "R12";
      12, 15:   return "R8";
      18:       return "R7/R8";
      default:  return "R6";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic probe(output logic [31:0] rq, output logic [31:0] ow);
    wr_en = 1'b0;
    addr  = 4'd0;
    #0.5 rq = rd_data;
    addr  = 4'd1;
    #0.5 ow = rd_data;
  endtask

  task automatic drive(logic we, logic [3:0] a, logic [31:0] d);
    wr_en   = we;
    addr    = a;
    wr_data = d;
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] rq, ow;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    probe(rq, ow);
    check("R11 reset req", rq, 32'h0);
    check("R11 reset owner", ow, 32'h0);
    check("R11 reset pulse", {31'h0, owner_changed}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].we, VEC[i].a, VEC[i].d);
      @(negedge clk);
      probe(rq, ow);
      check({tag_of(i), " req"}, rq, {16'h0, VEC[i].exp_req});
      check({tag_of(i), " owner"}, ow, {16'h0, VEC[i].exp_own});
      check({"R10 pulse ", tag_of(i)}, {31'h0, owner_changed}, {31'h0, VEC[i].exp_chg});
      check("R4 single owner", ($countones(ow) <= 1) ? 32'h1 : 32'h0, 32'h1);
    end

    drive(1'b1, 4'd0, 32'h0000_0003);
    @(negedge clk);
    drive(1'b0, 4'd3, 32'h0);
    #0.5 check("R12 unmapped read", rd_data, 32'h0);
    @(negedge clk);
    probe(rq, ow);
    check("R8 grant before reset", ow, 32'h0000_0001);
    rst_n = 1'b0;
    #0.5;
    probe(rq, ow);
    check("R11 mid-run reset req", rq, 32'h0);
    check("R11 mid-run reset owner", ow, 32'h0);
    check("R11 mid-run reset pulse", {31'h0, owner_changed}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    probe(rq, ow);
    check("R5 free after reset", ow, 32'h0);
    finish_run();
  end
endmodule